// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a PWM action stage and the gate drivers of a half-bridge or H-bridge leg. It receives two raw PWM levels (A and B) and produces a pair of gate-drive outputs. Each output can be given a programmed gap after a switching edge, so that the two switches of one leg are never on together.

Two independent delay paths do the timing. The rising path holds its output low until its source has been high for a programmed number of time-base ticks. The falling path holds its output high for a programmed number of ticks after its source drops. A source selector picks raw A or raw B for each path. An output selector picks, for each gate, either the delayed value or its own raw input. A polarity selector can invert each delayed value; with A feeding both paths and the falling-path value inverted on gate B, the pair becomes active-high complementary.

All mode and delay settings are presented on input ports. They are copied into the working registers only on the clock edge where the period-zero strobe is high, so a gap already in progress is never cut short. Selecting raw on both outputs gives bypass: the raw levels pass straight through, each output set by its own input.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is high, and on the first cycles after it, gate_a and gate_b are 0. The working configuration after reset is bypass (output select 00), with zero delays.
- R2: When out_sel bit 0 is 0, gate_a equals pwm_a_in delayed by one clock. When out_sel bit 1 is 0, gate_b equals pwm_b_in delayed by one clock. In this case the delays and the polarity settings have no effect.
- R3: When out_sel bit 0 is 1 and pol_sel bit 0 is 0, gate_a is high in a given cycle only if the rising-path source has been high on that tick and on the rise_dly ticks before it. gate_a drops on the same cycle as the source, which adds rise_dly ticks to the rising edge only.
- R4: A source pulse that stays high for rise_dly ticks or fewer produces no pulse at all on the rising-path output.
- R5: When out_sel bit 1 is 1 and pol_sel bit 1 is 0, gate_b is high in a given cycle if the falling-path source was high on that tick or on any of the fall_dly ticks before it. This adds fall_dly ticks to the falling edge only.
- R6: If the falling-path source rises again before fall_dly ticks of low time have passed, the pending fall is cancelled and the output stays high.
- R7: A delay value of 0 means the path adds no delay, so its output matches the raw source with the same one-clock latency as bypass.
- R8: pol_sel bit 0 inverts the rising-path value on gate_a, and pol_sel bit 1 inverts the falling-path value on gate_b. With src_sel=00, out_sel=11 and pol_sel=10 (active-high complementary), gate_a and gate_b are never high together.
- R9: The rising and falling delays are separate counts and may differ (for example 10 and 40). A falling delay longer than the source low time is not clamped: in complementary mode gate_b then stays low through that whole gap.
- R10: src_sel bit 0 selects the rising-path source and src_sel bit 1 selects the falling-path source (0 = pwm_a_in, 1 = pwm_b_in). When both bits are 0, pwm_b_in has no effect on either output.
- R11: src_sel, out_sel, pol_sel, rise_dly and fall_dly are taken into the working configuration only on a clock edge where period_zero is 1. Between such edges the previous configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick enable for the delay counters |
| period_zero | input | 1 | Strobe at time-base zero; loads the pending configuration |
| pwm_a_in | input | 1 | Raw PWM level A |
| pwm_b_in | input | 1 | Raw PWM level B |
| src_sel | input | 2 | Source per path: bit 0 rising, bit 1 falling (0 = A, 1 = B) |
| out_sel | input | 2 | Bit 0: gate_a takes the rising path; bit 1: gate_b takes the falling path |
| pol_sel | input | 2 | Bit 0 inverts the rising-path value, bit 1 inverts the falling-path value |
| rise_dly | input | DLY_W | Rising-edge delay in ticks |
| fall_dly | input | DLY_W | Falling-edge delay in ticks |
| gate_a | output | 1 | Gate drive A |
| gate_b | output | 1 | Gate drive B |

## Verification
Periodic raw waveforms with chosen periods, high times and phase offsets are applied to A and B under each configuration. The expected gate levels are computed from a per-cycle window over the source history. Wide pulses show the plain edge shift, while pulses no longer than the delay, or low gaps shorter than the falling delay, separate correct swallowing and cancelling from a counter that restarts or clamps. In the complementary run, B carries a pattern unrelated to A, and the source-swap runs use A and B patterns with different periods, so a wrong source selection shows up directly. A pending configuration held without the period-zero strobe, followed by the strobe itself, separates shadow loading from immediate loading.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Source choice for one delay path
    typedef enum logic {
        SRC_RAW_A = 1'b0,
        SRC_RAW_B = 1'b1
    } db_src_e;

    // Mode bits of the working configuration
    typedef struct packed {
        logic [1:0] src;   // bit0 rising path source, bit1 falling path source
        logic [1:0] outm;  // bit0 gate_a uses rising path, bit1 gate_b uses falling path
        logic [1:0] pol;   // bit0 invert rising value, bit1 invert falling value
    } db_mode_t;

    localparam db_mode_t DB_MODE_RESET = '{src: 2'b00, outm: 2'b00, pol: 2'b00};

    function automatic logic db_source(logic sel, logic raw_a, logic raw_b);
        return (sel == SRC_RAW_B) ? raw_b : raw_a;
    endfunction

    function automatic logic db_pick(logic use_dly, logic inv, logic dly_v, logic raw_v);
        return use_dly ? (dly_v ^ inv) : raw_v;
    endfunction

endpackage

// File: rtl/db_shadow.sv
module db_shadow
    import dbg_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  db_mode_t      nxt_mode,
    input  logic [DW-1:0] nxt_red,
    input  logic [DW-1:0] nxt_fed,
    output db_mode_t      cur_mode,
    output logic [DW-1:0] cur_red,
    output logic [DW-1:0] cur_fed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= DB_MODE_RESET;
            cur_red  <= '0;
            cur_fed  <= '0;
        end else if (load) begin
            cur_mode <= nxt_mode;
            cur_red  <= nxt_red;
            cur_fed  <= nxt_fed;
        end
    end

endmodule

// File: rtl/db_edge_path.sv
module db_edge_path #(
    parameter int   DW        = 10,
    parameter logic FALL_EDGE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          src_in,
    input  logic [DW-1:0] dly,
    output logic          dly_out
);

    localparam logic [DW-1:0] RUN_MAX = '1;

    logic          lvl;
    logic          hit;
    logic [DW-1:0] run_q;

    // The falling path is a rising-edge hold on the inverted source
    generate
        if (FALL_EDGE) begin : g_fall
            assign lvl     = ~src_in;
            assign dly_out = ~hit;
        end else begin : g_rise
            assign lvl     = src_in;
            assign dly_out = hit;
        end
    endgenerate

    // Ticks the qualifying level has been held, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= RUN_MAX;
        end else if (!lvl) begin
            run_q <= '0;
        end else if (tick && (run_q != RUN_MAX)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = lvl && (run_q >= dly);

endmodule

// File: rtl/db_out_stage.sv
module db_out_stage
    import dbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  db_mode_t mode,
    input  logic     raw_a,
    input  logic     raw_b,
    input  logic     rise_dv,
    input  logic     fall_dv,
    output logic     gate_a,
    output logic     gate_b
);

    localparam int NCH = 2;

    logic [NCH-1:0] raw_v;
    logic [NCH-1:0] dly_v;
    logic [NCH-1:0] gate_q;

    assign raw_v = {raw_b, raw_a};
    assign dly_v = {fall_dv, rise_dv};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    gate_q[ch] <= 1'b0;
                end else begin
                    gate_q[ch] <= db_pick(mode.outm[ch], mode.pol[ch], dly_v[ch], raw_v[ch]);
                end
            end
        end
    endgenerate

    assign gate_a = gate_q[0];
    assign gate_b = gate_q[1];

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import dbg_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             period_zero,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       out_sel,
    input  logic [1:0]       pol_sel,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             gate_a,
    output logic             gate_b
);

    db_mode_t         nxt_mode;
    db_mode_t         act_mode;
    logic [DLY_W-1:0] act_red;
    logic [DLY_W-1:0] act_fed;
    logic             rise_src;
    logic             fall_src;
    logic             rise_dv;
    logic             fall_dv;

    assign nxt_mode = '{src: src_sel, outm: out_sel, pol: pol_sel};

    db_shadow #(.DW(DLY_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (period_zero),
        .nxt_mode (nxt_mode),
        .nxt_red  (rise_dly),
        .nxt_fed  (fall_dly),
        .cur_mode (act_mode),
        .cur_red  (act_red),
        .cur_fed  (act_fed)
    );

    assign rise_src = db_source(act_mode.src[0], pwm_a_in, pwm_b_in);
    assign fall_src = db_source(act_mode.src[1], pwm_a_in, pwm_b_in);

    db_edge_path #(.DW(DLY_W), .FALL_EDGE(1'b0)) u_rise (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .src_in  (rise_src),
        .dly     (act_red),
        .dly_out (rise_dv)
    );

    db_edge_path #(.DW(DLY_W), .FALL_EDGE(1'b1)) u_fall (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .src_in  (fall_src),
        .dly     (act_fed),
        .dly_out (fall_dv)
    );

    db_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .mode    (act_mode),
        .raw_a   (pwm_a_in),
        .raw_b   (pwm_b_in),
        .rise_dv (rise_dv),
        .fall_dv (fall_dv),
        .gate_a  (gate_a),
        .gate_b  (gate_b)
    );

endmodule

// File: rtl/pwm_deadband_chk.sv
module pwm_deadband_chk
    import dbg_pkg::*;
#(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          period_zero,
    input logic          pwm_a_in,
    input logic          pwm_b_in,
    input logic          gate_a,
    input logic          gate_b,
    input db_mode_t      act_mode,
    input logic [DW-1:0] act_red,
    input logic [DW-1:0] act_fed,
    input logic          rise_in,
    input logic          fall_in
);

    logic compl_mode;
    assign compl_mode = (act_mode.src == 2'b00) && (act_mode.outm == 2'b11) && (act_mode.pol == 2'b10);

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!gate_a && !gate_b)); // R1

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
        !act_mode.outm[0] |=> (gate_a == $past(pwm_a_in))); // R2

    AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst)
        !act_mode.outm[1] |=> (gate_b == $past(pwm_b_in))); // R2

    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act_mode.outm[0] && !act_mode.pol[0] && !rise_in) |=> !gate_a); // R3

    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act_mode.outm[1] && !act_mode.pol[1] && fall_in) |=> gate_b); // R5

    AST_ZERO_RISE: assert property (@(posedge clk) disable iff (rst)
        (act_mode.outm[0] && !act_mode.pol[0] && (act_red == '0)) |=> (gate_a == $past(rise_in))); // R7

    AST_ZERO_FALL: assert property (@(posedge clk) disable iff (rst)
        (act_mode.outm[1] && !act_mode.pol[1] && (act_fed == '0)) |=> (gate_b == $past(fall_in))); // R7

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        compl_mode |=> !(gate_a && gate_b)); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !period_zero |=> ($stable(act_mode) && $stable(act_red) && $stable(act_fed))); // R11

    AST_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (compl_mode && !pwm_a_in && pwm_b_in) |=> !gate_a); // R10

endmodule

bind pwm_deadband pwm_deadband_chk #(.DW(DLY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .period_zero (period_zero),
    .pwm_a_in    (pwm_a_in),
    .pwm_b_in    (pwm_b_in),
    .gate_a      (gate_a),
    .gate_b      (gate_b),
    .act_mode    (act_mode),
    .act_red     (act_red),
    .act_fed     (act_fed),
    .rise_in     (rise_src),
    .fall_in     (fall_src)
);

// File: tb/test_pwm_deadband.sv
module test_pwm_deadband;

    localparam int DLY_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b1;
    logic             period_zero = 1'b0;
    logic             pwm_a_in = 1'b0;
    logic             pwm_b_in = 1'b0;
    logic [1:0]       src_sel = 2'b00;
    logic [1:0]       out_sel = 2'b00;
    logic [1:0]       pol_sel = 2'b00;
    logic [DLY_W-1:0] rise_dly = '0;
    logic [DLY_W-1:0] fall_dly = '0;
    logic             gate_a;
    logic             gate_b;

    pwm_deadband #(.DLY_W(DLY_W)) i_pwm_deadband (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .period_zero (period_zero),
        .pwm_a_in    (pwm_a_in),
        .pwm_b_in    (pwm_b_in),
        .src_sel     (src_sel),
        .out_sel     (out_sel),
        .pol_sel     (pol_sel),
        .rise_dly    (rise_dly),
        .fall_dly    (fall_dly),
        .gate_a      (gate_a),
        .gate_b      (gate_b)
    );

    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected working configuration (bench-side view of R1 and R11)
    bit [1:0] e_src = 2'b00;
    bit [1:0] e_out = 2'b00;
    bit [1:0] e_pol = 2'b00;
    int       e_red = 0;
    int       e_fed = 0;

    // Waveform generator parameters
    int g_pa = 1, g_ha = 0, g_pb = 1, g_hb = 0, g_ob = 0;

    // Scoreboard queues
    int    q_cyc[$];
    bit    q_a[$];
    bit    q_b[$];
    string q_tag[$];

    function automatic bit raw_a(int i);
        if (i < 0) return 1'b0;
        return (i % g_pa) < g_ha;
    endfunction

    function automatic bit raw_b(int i);
        if (i < 0) return 1'b0;
        return ((i + g_ob) % g_pb) < g_hb;
    endfunction

    function automatic bit src_v(bit sel, int i);
        return sel ? raw_b(i) : raw_a(i);
    endfunction

    // Rising path: source high now and on the d ticks before (R3, R4)
    function automatic bit win_all(bit sel, int i, int d);
        for (int k = 0; k <= d; k++) if (!src_v(sel, i - k)) return 1'b0;
        return 1'b1;
    endfunction

    // Falling path: source high now or on any of the d ticks before (R5, R6)
    function automatic bit win_any(bit sel, int i, int d);
        for (int k = 0; k <= d; k++) if (src_v(sel, i - k)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_a(int i);
        return e_out[0] ? (win_all(e_src[0], i, e_red) ^ e_pol[0]) : raw_a(i);
    endfunction

    function automatic bit exp_b(int i);
        return e_out[1] ? (win_any(e_src[1], i, e_fed) ^ e_pol[1]) : raw_b(i);
    endfunction

    task automatic chk(bit act, bit exp, string tag, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
        end
    endtask

    // Monitor: compares each expected item in the cycle it belongs to
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
            chk(gate_a, q_a[0], q_tag[0], "gate_a");
            chk(gate_b, q_b[0], q_tag[0], "gate_b");
            void'(q_cyc.pop_front());
            void'(q_a.pop_front());
            void'(q_b.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            pwm_a_in = 1'b0;
            pwm_b_in = 1'b0;
        end
    endtask

    task automatic set_pending(bit [1:0] s, bit [1:0] o, bit [1:0] p, int r, int f);
        @(posedge clk); #1;
        src_sel  = s;
        out_sel  = o;
        pol_sel  = p;
        rise_dly = DLY_W'(r);
        fall_dly = DLY_W'(f);
    endtask

    task automatic load_cfg(bit [1:0] s, bit [1:0] o, bit [1:0] p, int r, int f);
        set_pending(s, o, p, r, f);
        period_zero = 1'b1;
        @(posedge clk); #1;
        period_zero = 1'b0;
        e_src = s; e_out = o; e_pol = p; e_red = r; e_fed = f;
        idle(64);
    endtask

    // Driver: applies a periodic pattern and pushes the expected gate levels
    task automatic run(int pa, int ha, int pb, int hb, int ob, int n, string tag);
        g_pa = pa; g_ha = ha; g_pb = pb; g_hb = hb; g_ob = ob;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pwm_a_in = raw_a(i);
            pwm_b_in = raw_b(i);
            q_cyc.push_back(cyc + 1);
            q_a.push_back(exp_a(i));
            q_b.push_back(exp_b(i));
            q_tag.push_back(tag);
        end
        idle(64);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(gate_a, 1'b0, "R1", "gate_a in reset");
        chk(gate_b, 1'b0, "R1", "gate_b in reset");
        @(posedge clk); #1;
        rst = 1'b0;
        idle(64);
        @(negedge clk);
        chk(gate_a, 1'b0, "R1", "gate_a after reset");
        chk(gate_b, 1'b0, "R1", "gate_b after reset");

        // R1 / R11: pending complementary setup without strobe, bypass still active
        set_pending(2'b00, 2'b11, 2'b10, 3, 3);
        run(12, 5, 9, 4, 2, 60, "R11");

        // R2: bypass ignores delays and polarity
        load_cfg(2'b00, 2'b00, 2'b11, 5, 5);
        run(16, 5, 10, 3, 4, 64, "R2");

        // R3 / R4: rising delay of 4 on gate_a
        load_cfg(2'b00, 2'b01, 2'b00, 4, 0);
        run(20, 9, 7, 2, 1, 80, "R3");
        run(10, 4, 7, 2, 1, 60, "R4");

        // R5 / R6: falling delay of 6 on gate_b
        load_cfg(2'b00, 2'b10, 2'b00, 0, 6);
        run(20, 8, 9, 3, 0, 80, "R5");
        run(10, 6, 9, 3, 0, 60, "R6");

        // R7: zero delays on both paths
        load_cfg(2'b00, 2'b11, 2'b00, 0, 0);
        run(14, 5, 9, 4, 2, 56, "R7");

        // R8 / R9: active-high complementary, delays 10 and 40, B toggling but unused
        load_cfg(2'b00, 2'b11, 2'b10, 10, 40);
        run(120, 50, 7, 3, 0, 240, "R8");
        run(60, 30, 11, 5, 2, 180, "R9");

        // R10: source swaps
        load_cfg(2'b11, 2'b11, 2'b00, 3, 3);
        run(15, 6, 11, 7, 3, 90, "R10");
        load_cfg(2'b01, 2'b11, 2'b00, 2, 5);
        run(13, 7, 17, 9, 5, 90, "R10");

        // R11: new pending config held until the strobe
        load_cfg(2'b00, 2'b11, 2'b10, 2, 3);
        set_pending(2'b00, 2'b00, 2'b00, 0, 0);
        run(13, 6, 9, 4, 0, 50, "R11");
        load_cfg(2'b00, 2'b00, 2'b00, 0, 0);
        run(13, 6, 9, 4, 0, 50, "R11");

        finish_run();
    end

endmodule